// File: doc/BRIEF.md
# Active Goal Queue Handler

This block keeps track of every goal that is currently live in a cyclic goal-processing pipeline. The queue is built from four FIFOs that always push and pop together: goal address, storage slot, goal state copy and parent state copy. A fifth FIFO holds the storage slots that are not in use. Activating a new goal takes one slot from that free list and appends the new record to the tail of the queue.

Each turn pops the record at the head of the queue and offers it to the pipeline. The pipeline later returns the record with a verdict. A goal that must keep running goes back to the tail of the queue, together with the updated state and references the pipeline handed back, so every live goal gets one turn per rotation. A goal that succeeded or failed is reported once on a completion output, and its slot is returned to the tail of the free list.

A freeze input stops all movement. While it is high, every handshake is refused and no FIFO pointer changes.

Top module: `goal_queue_handler`

## Requirements
- R1: After reset the queue is empty (`iss_valid` low), the free list holds all DEPTH slots, and `act_ready` and `ret_ready` are high while `freeze` is low.
- R2: An accepted activation takes the slot at the head of the free list. After reset the slots are handed out in the order 0, 1, …, DEPTH-1, and slots freed later are handed out after them in the order they were freed. The slot travels with the goal record and appears on `iss_slot`.
- R3: `act_ready` is low whenever the free list is empty.
- R4: Records are issued in strict first-in first-out order. `iss_goal`, `iss_slot`, `iss_state` and `iss_parent` show the head record whenever `iss_valid` is high, and they stay unchanged until the record is taken with `iss_ready`.
- R5: A return with `ret_verdict` = 2'b00 (keep) appends the returned `ret_goal`, `ret_slot`, `ret_state` and `ret_parent` to the tail of the queue.
- R6: A return with any other verdict raises `done_valid` in the same cycle, with `done_goal`/`done_slot` equal to the returned references, and appends `ret_slot` to the tail of the free list.
- R7: A keep return has priority over a new activation. `act_ready` is low in any cycle in which `ret_valid` is high with verdict 2'b00.
- R8: While `freeze` is high, `act_ready`, `iss_valid`, `ret_ready` and `done_valid` are low and the contents of both queue and free list are unchanged.
- R9: The queue and the free list each accept a push and a pop in the same cycle without losing or duplicating an entry.
- R10: `done_ok` is high for verdict 2'b01 (success) and low for verdicts 2'b10 and 2'b11 (failure).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| freeze | input | 1 | Holds all FIFO state and refuses all handshakes |
| act_valid | input | 1 | New goal activation offered |
| act_ready | output | 1 | Activation accepted this cycle |
| act_goal | input | GADDR_W | Address of the goal being activated |
| act_state | input | STATE_W | Initial goal state copy |
| act_parent | input | STATE_W | Parent state copy |
| iss_valid | output | 1 | Head record offered to the pipeline |
| iss_ready | input | 1 | Pipeline takes the head record |
| iss_goal | output | GADDR_W | Issued goal address |
| iss_slot | output | SLOT_W | Issued storage slot |
| iss_state | output | STATE_W | Issued goal state copy |
| iss_parent | output | STATE_W | Issued parent state copy |
| ret_valid | input | 1 | Pipeline returns a processed record |
| ret_ready | output | 1 | Return accepted |
| ret_verdict | input | 2 | 00 keep, 01 success, 10/11 failure |
| ret_goal | input | GADDR_W | Returned goal address |
| ret_slot | input | SLOT_W | Returned storage slot |
| ret_state | input | STATE_W | Updated goal state copy |
| ret_parent | input | STATE_W | Updated parent state copy |
| done_valid | output | 1 | A goal left the queue this cycle |
| done_ok | output | 1 | The goal that left succeeded (1) or failed (0) |
| done_goal | output | GADDR_W | Address of the goal that left |
| done_slot | output | SLOT_W | Slot released by the goal that left |

## Verification
The bench builds the handler with DEPTH=8, GADDR_W=6 and STATE_W=8. With only eight slots, random traffic drains the free list often, so the stall on an empty free list, the reuse of freed slots in the order they were freed and a completely full queue all occur many times within a few thousand cycles. The narrow state width makes changes to the state written back by the pipeline easy to tell apart from the original copies. Random freeze cycles land in the middle of push-pop overlaps on both FIFOs.

// File: rtl/gqh_pkg.sv
package gqh_pkg;

   // verdict codes returned by the pipeline
   localparam logic [1:0] VERD_KEEP = 2'b00;
   localparam logic [1:0] VERD_PASS = 2'b01;

   function automatic logic verdict_retires(input logic [1:0] v);
      return v != VERD_KEEP;
   endfunction

   function automatic logic verdict_success(input logic [1:0] v);
      return v == VERD_PASS;
   endfunction

endpackage

// File: rtl/gqh_fifo.sv
module gqh_fifo #(
   parameter int WIDTH   = 8,
   parameter int DEPTH   = 16,
   parameter bit PRELOAD = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         hold,
   input  logic                         push,
   input  logic [WIDTH-1:0]             push_data,
   input  logic                         pop,
   output logic [WIDTH-1:0]             head,
   output logic                         empty,
   output logic [$clog2(DEPTH+1)-1:0]   count
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = $clog2(DEPTH+1);

   logic [WIDTH-1:0] mem [DEPTH];
   logic [PTR_W-1:0] rd_ptr;
   logic [PTR_W-1:0] wr_ptr;
   logic             do_push;
   logic             do_pop;

   assign do_push = push && !hold;
   assign do_pop  = pop  && !hold;
   assign head    = mem[rd_ptr];
   assign empty   = (count == '0);

   generate
      if (PRELOAD) begin : g_preload
         if (WIDTH < PTR_W) begin : g_bad_width
            $error("gqh_fifo: WIDTH too small to preload slot numbers");
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= WIDTH'(i);
               rd_ptr <= '0;
               wr_ptr <= '0;
               count  <= CNT_W'(DEPTH);
            end else begin
               if (do_push) begin
                  mem[wr_ptr] <= push_data;
                  wr_ptr      <= wr_ptr + 1'b1;
               end
               if (do_pop) rd_ptr <= rd_ptr + 1'b1;
               if (do_push && !do_pop)      count <= count + 1'b1;
               else if (do_pop && !do_push) count <= count - 1'b1;
            end
         end
      end else begin : g_plain
         always_ff @(posedge clk) begin
            if (do_push) mem[wr_ptr] <= push_data;
         end
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rd_ptr <= '0;
               wr_ptr <= '0;
               count  <= '0;
            end else begin
               if (do_push) wr_ptr <= wr_ptr + 1'b1;
               if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
               if (do_push && !do_pop)      count <= count + 1'b1;
               else if (do_pop && !do_push) count <= count - 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/gqh_ctrl.sv
module gqh_ctrl
   import gqh_pkg::*;
(
   input  logic       freeze,
   input  logic       act_valid,
   input  logic       fl_empty,
   input  logic       q_empty,
   input  logic       iss_ready,
   input  logic       ret_valid,
   input  logic [1:0] ret_verdict,
   output logic       act_ready,
   output logic       iss_valid,
   output logic       ret_ready,
   output logic       q_push,
   output logic       q_pop,
   output logic       q_from_ret,
   output logic       fl_push,
   output logic       fl_pop,
   output logic       done_valid,
   output logic       done_ok
);
   logic ret_keep;
   logic ret_fire;
   logic act_fire;

   always_comb begin
      ret_keep   = ret_valid && !verdict_retires(ret_verdict);
      ret_ready  = !freeze;
      ret_fire   = ret_valid && ret_ready;
      // a recirculating goal owns the queue write port this cycle
      act_ready  = !freeze && !fl_empty && !ret_keep;
      act_fire   = act_valid && act_ready;
      iss_valid  = !freeze && !q_empty;
      q_pop      = iss_valid && iss_ready;
      q_from_ret = ret_fire && !verdict_retires(ret_verdict);
      q_push     = q_from_ret || act_fire;
      fl_pop     = act_fire;
      fl_push    = ret_fire && verdict_retires(ret_verdict);
      done_valid = fl_push;
      done_ok    = verdict_success(ret_verdict);
   end

endmodule

// File: rtl/goal_queue_handler.sv
module goal_queue_handler #(
   parameter int DEPTH   = 16,
   parameter int GADDR_W = 8,
   parameter int STATE_W = 16,
   parameter int SLOT_W  = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               freeze,
   input  logic               act_valid,
   output logic               act_ready,
   input  logic [GADDR_W-1:0] act_goal,
   input  logic [STATE_W-1:0] act_state,
   input  logic [STATE_W-1:0] act_parent,
   output logic               iss_valid,
   input  logic               iss_ready,
   output logic [GADDR_W-1:0] iss_goal,
   output logic [SLOT_W-1:0]  iss_slot,
   output logic [STATE_W-1:0] iss_state,
   output logic [STATE_W-1:0] iss_parent,
   input  logic               ret_valid,
   output logic               ret_ready,
   input  logic [1:0]         ret_verdict,
   input  logic [GADDR_W-1:0] ret_goal,
   input  logic [SLOT_W-1:0]  ret_slot,
   input  logic [STATE_W-1:0] ret_state,
   input  logic [STATE_W-1:0] ret_parent,
   output logic               done_valid,
   output logic               done_ok,
   output logic [GADDR_W-1:0] done_goal,
   output logic [SLOT_W-1:0]  done_slot
);
   localparam int CNT_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("goal_queue_handler: DEPTH must be a power of two >= 2");
      end
      if (SLOT_W != $clog2(DEPTH)) begin : g_bad_slot
         $error("goal_queue_handler: SLOT_W must equal clog2(DEPTH)");
      end
      if (GADDR_W < 1 || STATE_W < 1) begin : g_bad_width
         $error("goal_queue_handler: widths must be positive");
      end
   endgenerate

   logic q_push, q_pop, q_from_ret, fl_push, fl_pop;
   logic q_empty, fl_empty;
   logic q_empty_slot, q_empty_state, q_empty_parent;
   logic [CNT_W-1:0] q_cnt, q_cnt_slot, q_cnt_state, q_cnt_parent, fl_cnt;
   logic [SLOT_W-1:0] fl_head;

   logic [GADDR_W-1:0] q_in_goal;
   logic [SLOT_W-1:0]  q_in_slot;
   logic [STATE_W-1:0] q_in_state;
   logic [STATE_W-1:0] q_in_parent;

   gqh_ctrl u_ctrl (
      .freeze      (freeze),
      .act_valid   (act_valid),
      .fl_empty    (fl_empty),
      .q_empty     (q_empty),
      .iss_ready   (iss_ready),
      .ret_valid   (ret_valid),
      .ret_verdict (ret_verdict),
      .act_ready   (act_ready),
      .iss_valid   (iss_valid),
      .ret_ready   (ret_ready),
      .q_push      (q_push),
      .q_pop       (q_pop),
      .q_from_ret  (q_from_ret),
      .fl_push     (fl_push),
      .fl_pop      (fl_pop),
      .done_valid  (done_valid),
      .done_ok     (done_ok)
   );

   // queue write data: recirculated record or fresh activation
   always_comb begin
      if (q_from_ret) begin
         q_in_goal   = ret_goal;
         q_in_slot   = ret_slot;
         q_in_state  = ret_state;
         q_in_parent = ret_parent;
      end else begin
         q_in_goal   = act_goal;
         q_in_slot   = fl_head;
         q_in_state  = act_state;
         q_in_parent = act_parent;
      end
   end

   // four lanes of the active queue, stepped by the same push/pop
   gqh_fifo #(.WIDTH(GADDR_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_q_goal (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .push(q_push), .push_data(q_in_goal), .pop(q_pop),
      .head(iss_goal), .empty(q_empty), .count(q_cnt)
   );

   gqh_fifo #(.WIDTH(SLOT_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_q_slot (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .push(q_push), .push_data(q_in_slot), .pop(q_pop),
      .head(iss_slot), .empty(q_empty_slot), .count(q_cnt_slot)
   );

   gqh_fifo #(.WIDTH(STATE_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_q_state (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .push(q_push), .push_data(q_in_state), .pop(q_pop),
      .head(iss_state), .empty(q_empty_state), .count(q_cnt_state)
   );

   gqh_fifo #(.WIDTH(STATE_W), .DEPTH(DEPTH), .PRELOAD(1'b0)) u_q_parent (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .push(q_push), .push_data(q_in_parent), .pop(q_pop),
      .head(iss_parent), .empty(q_empty_parent), .count(q_cnt_parent)
   );

   // free slot list, filled with every slot number at reset
   gqh_fifo #(.WIDTH(SLOT_W), .DEPTH(DEPTH), .PRELOAD(1'b1)) u_free (
      .clk(clk), .rst_n(rst_n), .hold(freeze),
      .push(fl_push), .push_data(ret_slot), .pop(fl_pop),
      .head(fl_head), .empty(fl_empty), .count(fl_cnt)
   );

   assign done_goal = ret_goal;
   assign done_slot = ret_slot;

endmodule

// File: rtl/gqh_chk.sv
module gqh_chk
   import gqh_pkg::*;
#(
   parameter int DEPTH   = 16,
   parameter int GADDR_W = 8,
   parameter int CNT_W   = $clog2(DEPTH+1)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               freeze,
   input logic               act_valid,
   input logic               act_ready,
   input logic               iss_valid,
   input logic               iss_ready,
   input logic [GADDR_W-1:0] iss_goal,
   input logic               ret_valid,
   input logic               ret_ready,
   input logic [1:0]         ret_verdict,
   input logic               done_valid,
   input logic [CNT_W-1:0]   q_cnt,
   input logic [CNT_W-1:0]   q_cnt_slot,
   input logic [CNT_W-1:0]   q_cnt_state,
   input logic [CNT_W-1:0]   q_cnt_parent,
   input logic               q_empty_slot,
   input logic               q_empty_state,
   input logic               q_empty_parent,
   input logic [CNT_W-1:0]   fl_cnt
);

   // R3
   no_alloc_when_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_cnt == '0) |-> !act_ready);

   // R7
   keep_beats_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_verdict == VERD_KEEP) |-> !act_ready);

   // R8
   freeze_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |-> (!act_ready && !iss_valid && !ret_ready && !done_valid));

   // R8
   freeze_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      freeze |=> (q_cnt == $past(q_cnt) && fl_cnt == $past(fl_cnt)));

   // R6
   slot_reclaim_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done_valid && !(act_valid && act_ready)) |=> (fl_cnt == $past(fl_cnt) + 1'b1));

   // R5
   recirc_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ret_valid && ret_ready && ret_verdict == VERD_KEEP && !(iss_valid && iss_ready))
      |=> (q_cnt == $past(q_cnt) + 1'b1));

   // R4
   head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid && !iss_ready) |=> (freeze || (iss_valid && iss_goal == $past(iss_goal))));

   // R2
   slot_conserve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, q_cnt} + {1'b0, fl_cnt}) <= (CNT_W+1)'(DEPTH));

   // R9
   lanes_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (q_cnt == q_cnt_slot && q_cnt == q_cnt_state && q_cnt == q_cnt_parent &&
       q_empty_slot == (q_cnt == '0) && q_empty_state == q_empty_parent));

endmodule

bind goal_queue_handler gqh_chk #(.DEPTH(DEPTH), .GADDR_W(GADDR_W)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .freeze         (freeze),
   .act_valid      (act_valid),
   .act_ready      (act_ready),
   .iss_valid      (iss_valid),
   .iss_ready      (iss_ready),
   .iss_goal       (iss_goal),
   .ret_valid      (ret_valid),
   .ret_ready      (ret_ready),
   .ret_verdict    (ret_verdict),
   .done_valid     (done_valid),
   .q_cnt          (q_cnt),
   .q_cnt_slot     (q_cnt_slot),
   .q_cnt_state    (q_cnt_state),
   .q_cnt_parent   (q_cnt_parent),
   .q_empty_slot   (q_empty_slot),
   .q_empty_state  (q_empty_state),
   .q_empty_parent (q_empty_parent),
   .fl_cnt         (fl_cnt)
);

// File: tb/goal_queue_handler_tb.sv
module goal_queue_handler_tb;
   localparam int DEPTH = 8;
   localparam int GW    = 6;
   localparam int SW    = 8;
   localparam int LW    = 3;

   typedef struct packed {
      logic [GW-1:0] goal;
      logic [LW-1:0] slot;
      logic [SW-1:0] st;
      logic [SW-1:0] par;
   } rec_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic freeze = 1'b0;
   logic act_valid = 1'b0;
   logic act_ready;
   logic [GW-1:0] act_goal = '0;
   logic [SW-1:0] act_state = '0;
   logic [SW-1:0] act_parent = '0;
   logic iss_valid;
   logic iss_ready = 1'b0;
   logic [GW-1:0] iss_goal;
   logic [LW-1:0] iss_slot;
   logic [SW-1:0] iss_state;
   logic [SW-1:0] iss_parent;
   logic ret_valid = 1'b0;
   logic ret_ready;
   logic [1:0] ret_verdict = 2'b00;
   logic [GW-1:0] ret_goal = '0;
   logic [LW-1:0] ret_slot = '0;
   logic [SW-1:0] ret_state = '0;
   logic [SW-1:0] ret_parent = '0;
   logic done_valid;
   logic done_ok;
   logic [GW-1:0] done_goal;
   logic [LW-1:0] done_slot;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   goal_queue_handler #(.DEPTH(DEPTH), .GADDR_W(GW), .STATE_W(SW)) u_dut (
      .clk(clk), .rst_n(rst_n), .freeze(freeze),
      .act_valid(act_valid), .act_ready(act_ready), .act_goal(act_goal),
      .act_state(act_state), .act_parent(act_parent),
      .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_goal(iss_goal),
      .iss_slot(iss_slot), .iss_state(iss_state), .iss_parent(iss_parent),
      .ret_valid(ret_valid), .ret_ready(ret_ready), .ret_verdict(ret_verdict),
      .ret_goal(ret_goal), .ret_slot(ret_slot), .ret_state(ret_state),
      .ret_parent(ret_parent),
      .done_valid(done_valid), .done_ok(done_ok), .done_goal(done_goal),
      .done_slot(done_slot)
   );

   // reference model
   rec_t mq[$];
   logic [LW-1:0] mfree[$];
   rec_t infl[$];
   logic last_both = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic exp_act_ready();
      return !freeze && mfree.size() > 0 && !(ret_valid && ret_verdict == 2'b00);
   endfunction

   function automatic logic exp_iss_valid();
      return !freeze && mq.size() > 0;
   endfunction

   function automatic logic exp_done();
      return ret_valid && !freeze && ret_verdict != 2'b00;
   endfunction

   // one cycle: drive at negedge, check, update model at posedge
   task automatic cycle(input int p_act, input int p_iss, input int p_ret,
                        input int p_frz, input int p_keep);
      logic ea, ei, ed, ia, ra, aa, qpush, qpop, fpush, fpop;
      rec_t h, r;
      @(negedge clk);
      freeze     = ($urandom_range(99) < p_frz);
      act_valid  = ($urandom_range(99) < p_act);
      act_goal   = GW'($urandom);
      act_state  = SW'($urandom);
      act_parent = SW'($urandom);
      iss_ready  = ($urandom_range(99) < p_iss);
      ret_valid  = (infl.size() > 0) && ($urandom_range(99) < p_ret);
      if (ret_valid) begin
         r = infl[0];
         ret_goal   = r.goal;
         ret_slot   = r.slot;
         ret_state  = r.st ^ SW'($urandom);
         ret_parent = r.par + 1'b1;
         ret_verdict = ($urandom_range(99) < p_keep) ? 2'b00 : 2'($urandom_range(1, 3));
      end
      #1;
      ea = exp_act_ready();
      ei = exp_iss_valid();
      ed = exp_done();
      chk(freeze ? "R8 act_ready" :
          (ret_valid && ret_verdict == 2'b00) ? "R7 act_ready" : "R3 act_ready",
          act_ready, ea);
      chk(freeze ? "R8 iss_valid" : "R4 iss_valid", iss_valid, ei);
      chk("R8 ret_ready", ret_ready, !freeze);
      chk(freeze ? "R8 done_valid" : "R6 done_valid", done_valid, ed);
      if (last_both) chk("R9 iss_valid after overlap", iss_valid, ei);
      if (ei) begin
         h = mq[0];
         chk("R4 iss_goal", iss_goal, h.goal);
         chk("R2 iss_slot", iss_slot, h.slot);
         chk("R5 iss_state", iss_state, h.st);
         chk("R5 iss_parent", iss_parent, h.par);
      end
      if (ed) begin
         chk("R10 done_ok", done_ok, ret_verdict == 2'b01);
         chk("R6 done_goal", done_goal, ret_goal);
         chk("R6 done_slot", done_slot, ret_slot);
      end
      @(posedge clk);
      ia = ei && iss_ready;
      ra = ret_valid && !freeze;
      aa = act_valid && ea;
      qpop = ia; qpush = 1'b0; fpush = 1'b0; fpop = 1'b0;
      if (ia) begin
         infl.push_back(mq[0]);
         void'(mq.pop_front());
      end
      if (aa) begin
         r.goal = act_goal; r.slot = mfree[0]; r.st = act_state; r.par = act_parent;
         void'(mfree.pop_front());
         mq.push_back(r);
         qpush = 1'b1; fpop = 1'b1;
      end
      if (ra) begin
         void'(infl.pop_front());
         if (ret_verdict == 2'b00) begin
            r.goal = ret_goal; r.slot = ret_slot; r.st = ret_state; r.par = ret_parent;
            mq.push_back(r);
            qpush = 1'b1;
         end else begin
            mfree.push_back(ret_slot);
            fpush = 1'b1;
         end
      end
      last_both = (qpush && qpop) || (fpush && fpop);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_1234));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < DEPTH; i++) mfree.push_back(LW'(i));
      #1;
      // R1 reset state
      chk("R1 iss_valid", iss_valid, 1'b0);
      chk("R1 act_ready", act_ready, 1'b1);
      chk("R1 ret_ready", ret_ready, 1'b1);
      chk("R1 done_valid", done_valid, 1'b0);
      // R2/R3: fill every slot without issuing, then the free list is dry
      for (int i = 0; i < DEPTH + 3; i++) cycle(100, 0, 0, 0, 0);
      chk("R3 free list empty stalls", act_ready, 1'b0);
      // R2: drain in order, checks slots 0..DEPTH-1 via model
      for (int i = 0; i < 20; i++) cycle(0, 100, 0, 0, 0);
      // return all as retired, in order, to refill the free list
      for (int i = 0; i < 20; i++) cycle(0, 0, 100, 0, 0);
      // R8 freeze with everything offered
      for (int i = 0; i < 6; i++) cycle(100, 100, 100, 100, 50);
      // random mixes
      for (int i = 0; i < 1500; i++) cycle(60, 60, 60, 0, 60);
      for (int i = 0; i < 1500; i++) cycle(90, 40, 70, 10, 80);
      for (int i = 0; i < 1500; i++) cycle(30, 90, 90, 5, 20);
      for (int i = 0; i < 1500; i++) cycle(80, 80, 80, 15, 50);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule